// File: doc/BRIEF.md
# Lane Interleaved-Parity Monitor

This block watches the receive side of one lane of a multi-lane 64b/66b physical coding layer, after the lane has been aligned. Each clock it may accept one 66-bit block together with a flag that marks the block as an alignment marker. Over every span that runs from one marker block up to the block before the next marker, it folds all octets and both sync bits into an 8-bit interleaved even-parity value. It then compares that value with the parity byte that the next marker carries.

A mismatch has one effect only. The block raises a one-cycle error pulse and adds one to a 16-bit error counter. A management agent polls that counter, and each poll clears it. The block only observes the lane. No output feeds back into lock, alignment or deskew logic. While the lane is not aligned, the block ignores its input. The first marker after reset, or after alignment returns, is not checked. That marker only opens a new span.

A marker appears about every 16,384 blocks, so at full lane rate there are about ten thousand markers per second. The 16-bit counter therefore cannot fill between polls made once per second, even if every marker fails. The counter saturates at all ones to cover a slower poll.

Top module: `lane_parity_monitor`

## Requirements
- R1: Block bit 0 is sync bit 0 and bit 1 is sync bit 1. Octet k occupies bits 2+8k to 9+8k, LSB first. Parity bit b is even parity over bit b of all eight octets of every block in the span. Sync bit 0 is also folded into parity bit 4, and sync bit 1 into parity bit 3.
- R2: A span starts with a marker block, including that marker's own bytes, and ends with the last block before the next marker. The received parity is octet 3 (bits 26 to 33) of that next marker.
- R3: When a checked marker's octet 3 differs from the computed parity in any bit, err_pulse is high for exactly the cycle after the marker is accepted, and err_count rises by one on the same edge. On a match, neither output changes.
- R4: The first marker accepted after reset, or after lane_aligned has been low, is never checked. It only starts a new span.
- R5: err_count stops at 0xFFFF and does not wrap.
- R6: rd_strobe clears err_count on the next edge, and err_count still shows the old value during the strobe cycle. When a strobe and a mismatch fall in the same cycle, err_count becomes 1.
- R7: Cycles with blk_valid low do not change the span parity, whatever blk_data holds.
- R8: After reset, err_count is 0 and err_pulse is 0.
- R9: Any burst of 1 to 5 consecutive flipped bits inside one block of a span is detected at the closing marker.
- R10: While lane_aligned is low, no block or marker is checked or counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_aligned | input | 1 | High while the lane is aligned |
| blk_valid | input | 1 | blk_data holds a block this cycle |
| blk_marker | input | 1 | The block is an alignment marker |
| blk_data | input | 66 | Received block, sync bits in bits 1:0 |
| rd_strobe | input | 1 | Management read: clears the counter |
| err_count | output | 16 | Saturating parity-error count |
| err_pulse | output | 1 | One-cycle pulse per failed marker |

## Verification
A management read and a counted mismatch can land on the same edge. The counter has to resolve that collision to 1, not to 0 and not to the old value plus one. The bench provokes the collision by first building up a nonzero count. It then raises rd_strobe in the very cycle that a marker with a wrong parity byte is accepted. It checks that err_count showed the old value during the strobe and reads 1 on the following cycle. The same collision is also checked against the saturated value 0xFFFF.

// File: rtl/lane_parity_monitor.sv
module lane_parity_monitor #(
  parameter int CNT_W     = 16,
  parameter int PAR_OCTET = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lane_aligned,
  input  logic             blk_valid,
  input  logic             blk_marker,
  input  logic [65:0]      blk_data,
  input  logic             rd_strobe,
  output logic [CNT_W-1:0] err_count,
  output logic             err_pulse
);

  localparam int                 OCTETS  = 8;
  localparam logic [CNT_W-1:0]   CNT_MAX = {CNT_W{1'b1}};

  logic [7:0] blk_par, span_par, rx_par;
  logic       opened, chk_now, mismatch;

  always_comb begin
    blk_par = '0;
    for (int k = 0; k < OCTETS; k++) blk_par ^= blk_data[2+8*k +: 8];
    blk_par[4] ^= blk_data[0];
    blk_par[3] ^= blk_data[1];
  end

  assign rx_par   = blk_data[2+8*PAR_OCTET +: 8];
  assign chk_now  = blk_valid && blk_marker && lane_aligned && opened;
  assign mismatch = chk_now && (span_par != rx_par);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      span_par  <= '0;
      opened    <= 1'b0;
      err_pulse <= 1'b0;
    end else begin
      err_pulse <= mismatch;
      if (!lane_aligned) opened <= 1'b0;
      else if (blk_valid) begin
        if (blk_marker) begin
          span_par <= blk_par;
          opened   <= 1'b1;
        end else begin
          span_par <= span_par ^ blk_par;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                             err_count <= '0;
    else if (rd_strobe)                     err_count <= mismatch ? CNT_W'(1) : '0;
    else if (mismatch && err_count != CNT_MAX) err_count <= err_count + 1'b1;
  end

  AST_PULSE_FROM_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(blk_valid && blk_marker && lane_aligned)); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_strobe && err_count != CNT_MAX) |=> (err_count == $past(err_count) + CNT_W'(err_pulse))); // R3
  AST_FIRST_UNCHECKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!opened && blk_valid && blk_marker) |=> !err_pulse); // R4
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == CNT_MAX && !rd_strobe) |=> err_count == CNT_MAX); // R5
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> err_count == CNT_W'(err_pulse)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_valid && lane_aligned) |=> $stable(span_par)); // R7
  AST_UNALIGNED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_aligned |=> !err_pulse); // R10

endmodule

// File: tb/sim_lane_parity_monitor.sv
module sim_lane_parity_monitor;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, lane_aligned = 0, blk_valid = 0, blk_marker = 0, rd_strobe = 0;
  logic [65:0] blk_data = '0;
  logic [15:0] err_count;
  logic err_pulse;

  int checks = 0, errors = 0, exp_cnt = 0;
  logic [7:0] tx_acc;

  always #(CLK_P/2) clk = ~clk;

  lane_parity_monitor u0 (.clk(clk), .rst_n(rst_n), .lane_aligned(lane_aligned),
    .blk_valid(blk_valid), .blk_marker(blk_marker), .blk_data(blk_data),
    .rd_strobe(rd_strobe), .err_count(err_count), .err_pulse(err_pulse));

  // {data blocks in span, burst start bit, burst length (0 = clean)}
  localparam int VEC [10][3] = '{
    '{10, 0, 0}, '{10, 0, 1}, '{7, 1, 1}, '{12, 20, 5}, '{5, 40, 3},
    '{3, 61, 5}, '{20, 7, 4}, '{1, 10, 0}, '{4, 33, 5}, '{0, 0, 0}};

  function automatic logic [7:0] ref_par(input logic [65:0] b);
    logic [7:0] p = '0;
    for (int i = 2; i < 66; i++) p[(i-2)%8] = p[(i-2)%8] ^ b[i];
    p[4] = p[4] ^ b[0];
    p[3] = p[3] ^ b[1];
    return p;
  endfunction

  function automatic logic [65:0] mk_marker(input logic [7:0] bip);
    return {8'hC2, 8'h36, 8'h84, 8'h5E, bip, 8'h7B, 8'hC9, 8'h3D, 2'b10};
  endfunction

  function automatic logic [65:0] mk_data(input int s, input int k);
    logic [31:0] x = 32'(s) * 32'h9E3779B1 + 32'(k) * 32'h7F4A7C15;
    return {x, x ^ 32'h5A5AC3C3, x[31:30]};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic m, input logic [65:0] d);
    @(negedge clk);
    blk_valid = v; blk_marker = m; blk_data = d;
  endtask

  task automatic send_marker(input logic [7:0] bip, input bit exp_err, input string tag);
    drive(1, 1, mk_marker(bip));
    drive(0, 0, '0);
    check(err_pulse == exp_err, {tag, " pulse"}, err_pulse, exp_err);
    if (exp_err) exp_cnt++;
    check(err_count == 16'(exp_cnt), {tag, " count"}, err_count, exp_cnt);
    tx_acc = ref_par(mk_marker(bip));
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(err_count == 0, "R8 count after reset", err_count, 0);
    check(err_pulse == 0, "R8 pulse after reset", err_pulse, 0);
    rst_n = 1; lane_aligned = 1;

    send_marker(8'hEE, 0, "R4 first marker after reset");

    for (int v = 0; v < 10; v++) begin
      for (int k = 0; k < VEC[v][0]; k++) begin
        logic [65:0] d = mk_data(v, k), sent;
        tx_acc ^= ref_par(d);
        sent = d;
        if (k == VEC[v][0] / 2)
          for (int j = 0; j < VEC[v][2]; j++) sent[VEC[v][1] + j] = ~sent[VEC[v][1] + j];
        drive(1, 0, sent);
      end
      send_marker(tx_acc, VEC[v][2] != 0, "R1 R2 R3 R9 span vector");
    end

    for (int k = 0; k < 6; k++) begin
      logic [65:0] d = mk_data(77, k);
      tx_acc ^= ref_par(d);
      drive(1, 0, d);
      drive(0, 1, ~d);
    end
    send_marker(tx_acc, 0, "R7 idle cycles ignored");
    send_marker(tx_acc ^ 8'h10, 1, "R3 single parity bit wrong");

    lane_aligned = 0;
    for (int k = 0; k < 4; k++) drive(1, 0, mk_data(5, k));
    drive(1, 1, mk_marker(8'h00));
    drive(0, 0, '0);
    check(err_pulse == 0, "R10 unaligned marker pulse", err_pulse, 0);
    check(err_count == 16'(exp_cnt), "R10 unaligned count", err_count, exp_cnt);
    lane_aligned = 1;
    send_marker(8'h55, 0, "R4 first marker after realign");
    send_marker(tx_acc, 0, "R2 span after realign");

    rd_strobe = 1;
    @(negedge clk);
    rd_strobe = 0; exp_cnt = 0;
    check(err_count == 0, "R6 read clears", err_count, 0);

    drive(1, 1, mk_marker(8'h00));
    repeat (65540) @(negedge clk);
    blk_valid = 0;
    check(err_count == 16'hFFFF, "R5 saturate", err_count, 16'hFFFF);
    repeat (2) @(negedge clk);
    check(err_count == 16'hFFFF, "R5 held", err_count, 16'hFFFF);

    blk_valid = 1; rd_strobe = 1;
    check(err_count == 16'hFFFF, "R6 value visible during strobe", err_count, 16'hFFFF);
    @(negedge clk);
    blk_valid = 0; rd_strobe = 0;
    check(err_count == 1, "R6 read with increment from full", err_count, 1);

    drive(1, 1, mk_marker(8'h00));
    repeat (2) @(negedge clk);
    blk_valid = 0;
    check(err_count == 3, "R3 count builds", err_count, 3);
    blk_valid = 1; rd_strobe = 1;
    @(negedge clk);
    blk_valid = 0; rd_strobe = 0;
    check(err_count == 1, "R6 read with increment", err_count, 1);
    check(err_pulse == 1, "R6 pulse on collision", err_pulse, 1);
    @(negedge clk);
    check(err_pulse == 0, "R3 pulse one cycle", err_pulse, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule